// File: doc/BRIEF.md
# Triple Interval Timer for a Sound Coprocessor

This block holds three independent interval timers for the processor of an audio subsystem. Each timer is a chain of three stages. A fixed prescaler divides the core clock. An 8-bit divider advances on every prescaler tick and fires when it reaches a programmable limit. A 4-bit event counter then counts those firings. Two of the timers run off a slow prescaler (one tick per 128 clocks). The third runs off a fast one (one tick per 16 clocks).

Software sets each timer's limit through a write strobe and gates each timer with an enable bit. It polls the event counter through a read strobe. The counter value is always visible on the output bus. Asserting the read strobe for one cycle consumes the value and clears the counter. Bus address decoding, the processor core and any interrupt logic sit outside this block.

Top module: `snd_timer_trio`

## Requirements
- R1: The prescaler ticks every 128 clock cycles for timers 0 and 1 and every 16 clock cycles for timer 2. With a limit of 1, timers 0 and 1 step their event counter every 128 cycles and timer 2 steps its counter every 16 cycles.
- R2: On each prescaler tick the divider first adds one to its 8-bit count, wrapping 255 to 0, and then compares the new count with the limit. A limit N from 1 to 255 gives exactly one event every N prescaler ticks.
- R3: A limit of 0 acts as 256: the event happens when the count wraps to 0, once every 256 prescaler ticks.
- R4: Each divider event adds exactly one to the timer's 4-bit event counter, which wraps from 15 to 0 and never saturates. No other change is possible while the timer is enabled and not being read.
- R5: A pulse on `lim_we[i]` loads `lim_wdata` into the limit of timer i only. The limit resets to 0.
- R6: On a clock edge where `rd_stb[i]` is high, timer i's counter becomes 0, or 1 if a divider event falls on that same edge. The value on `count_o` during that cycle is the value that is read.
- R7: While `tmr_en[i]` is low, timer i's divider and event counter are held at 0. The prescalers keep running, so after re-enabling, a full limit's worth of prescaler ticks passes before the first event.
- R8: After reset, every event counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tmr_en | input | 3 | Per-timer enable |
| lim_we | input | 3 | Per-timer limit write strobe |
| lim_wdata | input | 8 | Limit value shared by the write strobes |
| rd_stb | input | 3 | Per-timer read strobe; clears the counter on the edge |
| count_o | output | 12 | Event counters, timer i at bits [4i+3:4i] |

## Verification
The bench builds the block with its default parameters: prescale ratios of 128 and 16, an 8-bit divider and a 4-bit event counter. With these values both prescaler spacings can be observed directly. The fast timer keeps the slowest setting, a limit of 0 (one event per 4096 cycles), and a limit of 255 within a short run. Sixteen or more events at limit 1 on the fast timer are cheap, which lets the bench cover the 15-to-0 wrap. The fixed 16-cycle event spacing also lets the bench place a read exactly on, or away from, an event edge.

// File: rtl/snd_timer_pkg.sv
package snd_timer_pkg;
  localparam int unsigned NUM_TMR = 3;

  // Timer index that uses the fast prescaler; the rest use the slow one.
  localparam int unsigned FAST_IDX = 2;

  function automatic int unsigned pick_ratio(input int unsigned idx,
                                             input int unsigned slow,
                                             input int unsigned fast);
    return (idx == FAST_IDX) ? fast : slow;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned RATIO = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] phase_q, phase_d;

  always_comb begin
    tick_o  = (phase_q == LAST);
    phase_d = tick_o ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [DW-1:0] lim_i,
  output logic          hit_o
);
  logic [DW-1:0] cnt_q, cnt_d, bumped;

  always_comb begin
    bumped = cnt_q + 1'b1;          // wraps naturally, so limit 0 acts as 2**DW
    hit_o  = en_i && tick_i && (bumped == lim_i);
    cnt_d  = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (hit_o)  cnt_d = '0;
    else if (tick_i) cnt_d = bumped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_evcount.sv
module tmr_evcount #(
  parameter int unsigned OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [OW-1:0] cnt_o
);
  logic [OW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)      cnt_d = '0;
    else if (clr_i) cnt_d = inc_i ? OW'(1) : '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/snd_timer_trio.sv
module snd_timer_trio #(
  parameter int unsigned SLOW_RATIO = 128,
  parameter int unsigned FAST_RATIO = 16,
  parameter int unsigned LIM_W      = 8,
  parameter int unsigned CNT_W      = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [snd_timer_pkg::NUM_TMR-1:0]        tmr_en,
  input  logic [snd_timer_pkg::NUM_TMR-1:0]        lim_we,
  input  logic [LIM_W-1:0]                         lim_wdata,
  input  logic [snd_timer_pkg::NUM_TMR-1:0]        rd_stb,
  output logic [snd_timer_pkg::NUM_TMR*CNT_W-1:0]  count_o
);
  import snd_timer_pkg::*;

  logic [NUM_TMR-1:0] pre_tick;
  logic [NUM_TMR-1:0] div_hit;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [LIM_W-1:0] lim_q, lim_d;

    always_comb lim_d = lim_we[i] ? lim_wdata : lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim_q <= '0;
      else        lim_q <= lim_d;
    end

    tmr_prescaler #(.RATIO(pick_ratio(i, SLOW_RATIO, FAST_RATIO))) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (pre_tick[i])
    );

    tmr_divider #(.DW(LIM_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (tmr_en[i]),
      .tick_i (pre_tick[i]),
      .lim_i  (lim_q),
      .hit_o  (div_hit[i])
    );

    tmr_evcount #(.OW(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (tmr_en[i]),
      .inc_i  (div_hit[i]),
      .clr_i  (rd_stb[i]),
      .cnt_o  (count_o[i*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/snd_timer_trio_chk.sv
module snd_timer_trio_chk #(
  parameter int unsigned SLOW_RATIO = 128,
  parameter int unsigned FAST_RATIO = 16,
  parameter int unsigned CNT_W      = 4
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic [snd_timer_pkg::NUM_TMR-1:0]       tmr_en,
  input logic [snd_timer_pkg::NUM_TMR-1:0]       rd_stb,
  input logic [snd_timer_pkg::NUM_TMR*CNT_W-1:0] count_o,
  input logic                                    slow_tick,
  input logic                                    fast_tick
);
  import snd_timer_pkg::*;

  localparam int unsigned GW = $clog2(SLOW_RATIO) + 1;
  logic [GW-1:0] slow_gap, fast_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_gap <= '0;
      fast_gap <= '0;
    end else begin
      slow_gap <= slow_tick ? '0 : slow_gap + 1'b1;
      fast_gap <= fast_tick ? '0 : fast_gap + 1'b1;
    end
  end

  // R1
  a_r1_slow_period: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |-> (slow_gap == GW'(SLOW_RATIO - 1)));
  a_r1_fast_period: assert property (@(posedge clk) disable iff (!rst_n)
    fast_tick |-> (fast_gap == GW'(FAST_RATIO - 1)));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R7
    a_r7_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en[i] |=> (count_o[i*CNT_W +: CNT_W] == '0));
    // R6
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en[i] && rd_stb[i]) |=> (count_o[i*CNT_W +: CNT_W] <= CNT_W'(1)));
    // R4
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_en[i] && !rd_stb[i]) |=>
        ($stable(count_o[i*CNT_W +: CNT_W]) ||
         (count_o[i*CNT_W +: CNT_W] ==
          CNT_W'($past(count_o[i*CNT_W +: CNT_W]) + 1'b1))));
  end
endmodule

bind snd_timer_trio snd_timer_trio_chk #(
  .SLOW_RATIO (SLOW_RATIO),
  .FAST_RATIO (FAST_RATIO),
  .CNT_W      (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tmr_en    (tmr_en),
  .rd_stb    (rd_stb),
  .count_o   (count_o),
  .slow_tick (pre_tick[0]),
  .fast_tick (pre_tick[2])
);

// File: tb/sim_snd_timer_trio.sv
`timescale 1ns/1ps
module sim_snd_timer_trio;
  logic        clk;
  logic        rst_n;
  logic [2:0]  tmr_en;
  logic [2:0]  lim_we;
  logic [7:0]  lim_wdata;
  logic [2:0]  rd_stb;
  logic [11:0] count_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  snd_timer_trio u0 (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .lim_we(lim_we),
    .lim_wdata(lim_wdata), .rd_stb(rd_stb), .count_o(count_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] cnt_of(input int t);
    return count_o[t*4 +: 4];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Scoreboard: expected spacings between successive counter steps
  int    exp_q[$];
  bit    mon_arm = 0;
  int    mon_sel = 0;
  string mon_tag = "R1";
  bit    have_last = 0;
  int    last_t = 0;
  logic [3:0] prev = '0;

  always @(negedge clk) begin
    if (!mon_arm) begin
      have_last = 0;
      prev      = cnt_of(mon_sel);
    end else if (cnt_of(mon_sel) != prev) begin
      check(cnt_of(mon_sel) == 4'(prev + 1), "R4 step", cnt_of(mon_sel), 4'(prev + 1));
      if (have_last && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check((cyc - last_t) == e, mon_tag, cyc - last_t, e);
      end
      have_last = 1;
      last_t    = cyc;
      prev      = cnt_of(mon_sel);
    end
  end

  task automatic set_limit(input int t, input int v);
    @(negedge clk);
    lim_we[t] = 1'b1;
    lim_wdata = 8'(v);
    @(negedge clk);
    lim_we    = '0;
  endtask

  task automatic run_spacing(input int t, input int lim, input int n,
                             input int sp, input string tag);
    tmr_en[t] = 1'b0;
    set_limit(t, lim);
    @(negedge clk);
    mon_sel = t;
    mon_tag = tag;
    @(negedge clk);
    for (int k = 0; k < n; k++) exp_q.push_back(sp);
    tmr_en[t] = 1'b1;
    mon_arm   = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    mon_arm   = 1'b0;
    tmr_en[t] = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_change(input int t);
    logic [3:0] p;
    p = cnt_of(t);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (cnt_of(t) != p) return;
    end
  endtask

  // Watchdog
  initial begin
    wait (cyc >= 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tmr_en = '0; lim_we = '0; lim_wdata = '0; rd_stb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    check(count_o == 12'h000, "R8 reset", count_o, 0);

    // R1 prescaler spacings at limit 1
    run_spacing(0, 1, 3, 128, "R1 timer0");
    run_spacing(1, 1, 3, 128, "R1 timer1");
    run_spacing(2, 1, 3, 16,  "R1 timer2");
    // R2 ordinary limits
    run_spacing(0, 2,   2, 256,  "R2 limit2");
    run_spacing(2, 255, 2, 4080, "R2 limit255");
    // R3 limit 0 means 256
    run_spacing(2, 0, 2, 4096, "R3 limit0");
    // R4 wrap across 15 -> 0 (monitor checks every step value)
    run_spacing(2, 1, 20, 16, "R4 wrap");

    // R5: writing timer 2's limit leaves timer 1's limit (1) untouched
    set_limit(2, 3);
    tmr_en = 3'b010;
    wait_change(1);
    begin
      int t0, t1;
      t0 = cyc;
      wait_change(1);
      t1 = cyc;
      check((t1 - t0) == 128, "R5 limit isolation", t1 - t0, 128);
    end
    tmr_en = '0;
    @(negedge clk);

    // R6 read away from an event edge
    set_limit(2, 1);
    tmr_en[2] = 1'b1;
    repeat (3) wait_change(2);
    begin
      int v;
      v = cnt_of(2);
      check(v == 3, "R6 value read", v, 3);
      rd_stb[2] = 1'b1;
      @(negedge clk);
      rd_stb[2] = 1'b0;
      check(cnt_of(2) == 0, "R6 clear", cnt_of(2), 0);
    end
    // R6 read on an event edge counts from 0
    wait_change(2);
    repeat (15) @(negedge clk);
    rd_stb[2] = 1'b1;
    @(negedge clk);
    rd_stb[2] = 1'b0;
    check(cnt_of(2) == 1, "R6 read on event", cnt_of(2), 1);

    // R7 disable clears divider; prescaler phase continues
    tmr_en[2] = 1'b0;
    set_limit(2, 3);
    tmr_en[2] = 1'b1;
    wait_change(2);
    repeat (20) @(negedge clk);
    tmr_en[2] = 1'b0;
    @(negedge clk);
    check(cnt_of(2) == 0, "R7 counter cleared", cnt_of(2), 0);
    tmr_en[2] = 1'b1;
    begin
      int w;
      w = 0;
      while (cnt_of(2) == 0 && w < 1000) begin
        @(negedge clk);
        w++;
      end
      check(w == 43, "R7 restart delay", w, 43);
    end
    tmr_en = '0;
    @(negedge clk);
    check(count_o == 12'h000, "R7 all disabled", count_o, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule